// File: doc/BRIEF.md
# Sequential Table Search Engine

This block looks for a 4-bit key in a fixed table of seven constants, testing one table slot per clock cycle. A single-cycle pulse on `start_en` latches the key on `key_in` and begins a new scan at slot 0. The scan ends at the first slot that holds the key, or after the last slot when no slot holds it. The block then raises `done` and reports on `index_out` the slot where it stopped.

If no slot matches, the reported index is 7, which is one past the final slot. The table holds, by slot number 0 to 6, the values 0, 4, 15, 14, 2, 5 and 13.

A small state machine drives the scan. Its states are:
- **ST_IDLE**: the state after reset. `done` is high.
- **ST_SCAN**: a scan is running. `done` is low.
- **ST_HIT**: the scan found the key. `done` is high.
- **ST_MISS**: the scan found no match. `done` is high.

Its transitions are:
- **START**: any state goes to ST_SCAN when `start_en` is high.
- **MATCH**: ST_SCAN goes to ST_HIT when the slot under test equals the key.
- **EXHAUST**: ST_SCAN goes to ST_MISS when slot 6 does not match.
- **ADVANCE**: ST_SCAN stays in ST_SCAN and moves to the next slot.
- **HOLD**: ST_IDLE, ST_HIT and ST_MISS stay where they are while `start_en` is low.

Top module: `srch_engine`

## Requirements
- R1: After reset, `done` is 1 and `index_out` is 0.
- R2: When `start_en` is high at a rising edge, the key on `key_in` is latched. Right after that edge, `done` is 0 and `index_out` is 0.
- R3: During a scan, `index_out` equals the number of edges since the start edge. Slots are tested in rising order, one per cycle, beginning at 0.
- R4: When slot k is the first slot whose value equals the key, `done` rises k+1 edges after the start edge and `index_out` is k. The slot values for k = 0 to 6 are 0, 4, 15, 14, 2, 5 and 13.
- R5: When no slot holds the key, `done` rises 7 edges after the start edge and `index_out` is 7.
- R6: While `done` is high and `start_en` is low, `done` stays 1 and `index_out` stays unchanged. Changes on `key_in` have no effect in this period.
- R7: Every search ends no later than 10 edges (table size plus 3) after its start edge.
- R8: A `start_en` pulse during a running scan restarts the scan at slot 0 with the new key. Changes on `key_in` while a scan runs, without `start_en`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_en | input | 1 | One-cycle pulse that latches the key and starts a scan |
| key_in | input | 4 | Value to search for |
| done | output | 1 | High when no scan is running; `index_out` is valid |
| index_out | output | 3 | Matching slot, or 7 when there is no match |

## Verification
The test searches for every one of the 16 key values. This covers a match at each slot from 0 to 6, including the first and the last, and it also covers all nine absent values, which must give index 7 after the full scan. Watching `index_out` step by step during scans separates a correct rising-order scan from one that skips or repeats slots. Wiggling the key while the block is busy or finished, and restarting a scan partway through, separates a latched key from a live one, and a true restart from a scan that carries on.

// File: rtl/srch_pkg.sv
package srch_pkg;
    localparam int KEY_W = 4;
    localparam int N_ENT = 7;
    localparam int IDX_W = $clog2(N_ENT + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HIT,
        ST_MISS
    } srch_state_e;

    // Constant table; slot order decides which match is reported first.
    function automatic logic [KEY_W-1:0] tbl_value(input logic [IDX_W-1:0] slot);
        logic [KEY_W-1:0] v;
        case (slot)
            3'd0:    v = 4'd0;
            3'd1:    v = 4'd4;
            3'd2:    v = 4'd15;
            3'd3:    v = 4'd14;
            3'd4:    v = 4'd2;
            3'd5:    v = 4'd5;
            3'd6:    v = 4'd13;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/srch_rom.sv
module srch_rom #(
    parameter int KEY_W = srch_pkg::KEY_W,
    parameter int IDX_W = srch_pkg::IDX_W
) (
    input  logic [IDX_W-1:0] slot,
    output logic [KEY_W-1:0] value
);
    always_comb begin
        value = KEY_W'(srch_pkg::tbl_value(srch_pkg::IDX_W'(slot)));
    end
endmodule

// File: rtl/srch_ptr.sv
module srch_ptr #(
    parameter int IDX_W = srch_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] slot
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (clear) begin
            slot <= '0;
        end else if (advance) begin
            slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/srch_cmp.sv
module srch_cmp #(
    parameter int KEY_W = srch_pkg::KEY_W,
    parameter int IDX_W = srch_pkg::IDX_W,
    parameter int N_ENT = srch_pkg::N_ENT
) (
    input  logic [KEY_W-1:0] entry,
    input  logic [KEY_W-1:0] key,
    input  logic [IDX_W-1:0] slot,
    output logic             hit,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_ENT - 1);

    always_comb begin
        hit  = (entry == key);
        last = (slot == LAST_SLOT);
    end
endmodule

// File: rtl/srch_engine.sv
module srch_engine #(
    parameter int KEY_W = srch_pkg::KEY_W,
    parameter int N_ENT = srch_pkg::N_ENT,
    parameter int IDX_W = $clog2(N_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_en,
    input  logic [KEY_W-1:0] key_in,
    output logic             done,
    output logic [IDX_W-1:0] index_out
);
    import srch_pkg::*;

    localparam int LIMIT = N_ENT + 3;
    localparam int CNT_W = $clog2(LIMIT + 2);

    srch_state_e      state_q, state_d;
    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] entry;
    logic [IDX_W-1:0] slot;
    logic             hit, last, advance;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (start_en) begin
            key_q <= key_in;
        end
    end

    srch_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clear(start_en), .advance(advance), .slot(slot)
    );

    srch_rom #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_rom (
        .slot(slot), .value(entry)
    );

    srch_cmp #(.KEY_W(KEY_W), .IDX_W(IDX_W), .N_ENT(N_ENT)) u_cmp (
        .entry(entry), .key(key_q), .slot(slot), .hit(hit), .last(last)
    );

    // Next state and pointer control
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        if (start_en) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (hit) begin
                        state_d = ST_HIT;
                    end else begin
                        advance = 1'b1;
                        if (last) state_d = ST_MISS;
                    end
                end
                ST_IDLE, ST_HIT, ST_MISS: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        done      = (state_q != ST_SCAN);
        index_out = slot;
    end

    // Checking logic: cycles spent in the current search
    logic [CNT_W-1:0] busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (start_en) busy_cnt <= CNT_W'(1);
        else if (!done)    busy_cnt <= busy_cnt + 1'b1;
    end

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_en |=> (!done && index_out == '0));

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !start_en) |=> (index_out == $past(index_out) + 1'b1 || done));

    // R4
    hit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIT) |-> (entry == key_q && index_out < IDX_W'(N_ENT)));

    // R5
    miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MISS) |-> (index_out == IDX_W'(N_ENT)));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_en) |=> (done && $stable(index_out)));

    // R7
    bounded_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (int'(busy_cnt) <= LIMIT));
endmodule

// File: tb/srch_engine_bench.sv
module srch_engine_bench;
    localparam int CLK_PER = 10;
    localparam int TBL_N   = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_en = 1'b0;
    logic [3:0] key_in = '0;
    logic       done;
    logic [2:0] index_out;

    int checks = 0;
    int fails  = 0;
    int exp_idx_q[$];
    int exp_lat_q[$];

    always #(CLK_PER/2) clk = ~clk;

    srch_engine u_srch_engine (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .key_in(key_in),
        .done(done), .index_out(index_out)
    );

    function automatic int ref_entry(input int s);
        case (s)
            0: return 0;  1: return 4;  2: return 15; 3: return 14;
            4: return 2;  5: return 5;  6: return 13;
            default: return -1;
        endcase
    endfunction

    function automatic int ref_find(input int k);
        for (int s = 0; s < TBL_N; s++) if (ref_entry(s) == k) return s;
        return TBL_N;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        key_in   = 4'(k);
        start_en = 1'b1;
        @(negedge clk);
        start_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic search(input int k);
        int ix;
        ix = ref_find(k);
        exp_idx_q.push_back(ix);
        exp_lat_q.push_back(ix == TBL_N ? TBL_N : ix + 1);
        pulse(k);
        @(negedge clk);
        key_in = ~4'(k);     // R8: key change mid-scan must not matter
        wait_done();
    endtask

    // Monitor: scoreboard side
    initial begin
        bit busy = 1'b0;
        int lat  = 0;
        forever begin
            bit was_start;
            @(posedge clk);
            was_start = start_en;
            #1;
            if (!rst_n) begin
                busy = 1'b0;
            end else if (was_start) begin
                busy = 1'b1;
                lat  = 0;
                check(!done && index_out == 0, "R2", {31'd0, done}, 0);
            end else if (busy) begin
                lat++;
                if (!done) begin
                    check(int'(index_out) == lat, "R3", int'(index_out), lat);
                    check(lat <= TBL_N + 3, "R7", lat, TBL_N + 3);
                end else begin
                    int ei, el;
                    busy = 1'b0;
                    if (exp_idx_q.size() == 0) begin
                        check(1'b0, "R4", int'(index_out), -1);
                    end else begin
                        ei = exp_idx_q.pop_front();
                        el = exp_lat_q.pop_front();
                        check(int'(index_out) == ei, ei == TBL_N ? "R5" : "R4", int'(index_out), ei);
                        check(lat == el, ei == TBL_N ? "R5" : "R4", lat, el);
                        check(lat <= TBL_N + 3, "R7", lat, TBL_N + 3);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R1", {31'd0, done}, 1);
        check(index_out == 0, "R1", int'(index_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 16; k++) search(k);

        // R6: hold while finished, key wiggled
        search(14);
        for (int i = 0; i < 4; i++) begin
            key_in = 4'(i * 5);
            @(negedge clk);
            check(done == 1'b1 && index_out == 3'd3, "R6", int'(index_out), 3);
        end

        // R8: restart mid-scan of a miss with a new key
        pulse(3);
        @(negedge clk);
        exp_idx_q.push_back(6);
        exp_lat_q.push_back(7);
        pulse(13);
        wait_done();
        check(index_out == 3'd6, "R8", int'(index_out), 6);

        repeat (3) @(negedge clk);
        check(exp_idx_q.size() == 0, "R4", exp_idx_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule